// File: doc/BRIEF.md
# Plug-and-Play Configuration Port Decoder

This block is the card-side front end that gives host software access to a card's 256 byte-wide configuration registers through three single-byte I/O locations. The same three locations are shared by every card on the bus. It watches a simple synchronous I/O bus made of a 12-bit address, write data, a read strobe and a write strobe. The strobes are sampled on each rising clock edge. Two of the locations are fixed. The first is an index location at 0x279, which chooses the configuration register that later accesses target. The second is a data-write location at 0xA79. The third location is a data-read location whose address software programs at run time.

The card is told its handle on an input pin. Software selects one card by writing a handle through the data-write location while the index is 0x06. Every card compares that byte with its own handle. The matching card becomes selected, and all the others drop out. From then on, only the selected card stores data written to the data-write location, and only the selected card drives data when the programmable read location is read. All other cards leave the read-enable output low, so the shared data bus stays undriven by them.

Top module: `pnp_cfg_port`

## Requirements
- R1: After reset the selected flag is 0, the index is 0, rd_oe is 0 and rd_data is 0. The read location is disabled until it is programmed, so no read at any address drives the bus.
- R2: A write strobe at exactly address 0x279 loads the index from io_wdata. This happens whether or not the card is selected. A write that differs from 0x279 in any of the 12 address bits leaves the index unchanged.
- R3: A write strobe at exactly 0xA79 while the index is 0x06 sets card_sel to 1 when io_wdata equals card_handle, and to 0 otherwise. This happens whatever the previous selection was. card_sel changes on no other event.
- R4: A write strobe at 0xA79 while selected and with an index other than 0x06 stores io_wdata in the register at the index. The same write while unselected changes no register. A write to index 0x06 stores nothing.
- R5: A stored write to index 0x00 also sets the read location to the 12-bit address {2'b00, byte, 2'b11} and enables it. Byte 0x80 gives 0x203 and 0xFF gives 0x3FF. The previous read location stops responding.
- R6: A read strobe at exactly the enabled read location while selected gives rd_oe = 1 for exactly one cycle, in the cycle after the sampling edge. In that cycle rd_data holds the register at the index, with values taken before any write sampled on the same edge.
- R7: A read strobe while unselected, or at any address other than the enabled read location, leaves rd_oe at 0. Whenever rd_oe is 0, rd_data is 0.
- R8: Read strobes at the index location or the data-write location never drive the bus. Write strobes at the read location change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 12 | I/O address |
| io_wdata | input | 8 | Data written by the host |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| card_handle | input | 8 | Handle assigned to this card |
| rd_data | output | 8 | Read data, zero when not driving |
| rd_oe | output | 1 | Output enable for rd_data onto the shared bus |
| card_sel | output | 1 | Card is currently selected |

## Verification
A write strobe is applied at the edge that samples it. The index, selection, register contents and read location all hold their new values from that edge onward, so any later access sees them at once. Read results appear one cycle later, in rd_data and rd_oe for the cycle after the sampling edge, and are gone by the following cycle. The bench drives inputs on falling edges. A behavioural model is updated at each rising edge, and on every falling edge the model's rd_oe, rd_data and card_sel are compared with the outputs, so each result is checked in exactly the cycle it is due.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;
  // Fixed bus locations (12-bit compare)
  localparam int INDEX_LOC = 'h279;
  localparam int WDATA_LOC = 'hA79;
  // Register indices with side effects
  localparam int RDLOC_IDX  = 'h00;
  localparam int SELECT_IDX = 'h06;

  typedef struct packed {
    logic index_wr;   // write strobe at index location
    logic data_wr;    // write strobe at data-write location
    logic data_rd;    // read strobe at enabled read location
  } port_hit_t;
endpackage

// File: rtl/pnp_port_decode.sv
module pnp_port_decode
  import pnp_cfg_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic          rdloc_load,
  output port_hit_t     hit
);
  localparam int PAD = AW - DW - 2;

  logic [AW-1:0] rdloc_q;
  logic          rdloc_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdloc_q    <= '0;
      rdloc_en_q <= 1'b0;
    end else if (rdloc_load) begin
      rdloc_q    <= {{PAD{1'b0}}, io_wdata, 2'b11};
      rdloc_en_q <= 1'b1;
    end
  end

  always_comb begin
    hit.index_wr = io_wr && (io_addr == AW'(INDEX_LOC));
    hit.data_wr  = io_wr && (io_addr == AW'(WDATA_LOC));
    hit.data_rd  = io_rd && rdloc_en_q && (io_addr == rdloc_q);
  end
endmodule

// File: rtl/pnp_card_sel.sv
module pnp_card_sel
  import pnp_cfg_pkg::*;
#(
  parameter int DW   = 8,
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  port_hit_t       hit,
  input  logic [DW-1:0]   io_wdata,
  input  logic [DW-1:0]   card_handle,
  output logic [IDXW-1:0] idx,
  output logic            selected,
  output logic            reg_we,
  output logic            rdloc_load
);
  logic [IDXW-1:0] idx_q;
  logic            sel_q;
  logic            at_select;

  assign at_select = (idx_q == IDXW'(SELECT_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sel_q <= 1'b0;
    end else begin
      if (hit.index_wr)
        idx_q <= io_wdata[IDXW-1:0];
      if (hit.data_wr && at_select)
        sel_q <= (io_wdata == card_handle);
    end
  end

  assign reg_we     = hit.data_wr && sel_q && !at_select;
  assign rdloc_load = reg_we && (idx_q == IDXW'(RDLOC_IDX));
  assign idx        = idx_q;
  assign selected   = sel_q;
endmodule

// File: rtl/pnp_cfg_regfile.sv
module pnp_cfg_regfile #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (we && (idx == IDXW'(i)))
        mem[i] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/pnp_cfg_port.sv
module pnp_cfg_port
  import pnp_cfg_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 8,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [DW-1:0] card_handle,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe,
  output logic          card_sel
);
  localparam int IDXW = $clog2(DEPTH);

  port_hit_t       hit;
  logic [IDXW-1:0] cur_idx;
  logic            sel;
  logic            reg_we;
  logic            rdloc_load;
  logic [DW-1:0]   reg_rdata;
  logic            rd_grant;

  pnp_port_decode #(.AW(AW), .DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .rdloc_load(rdloc_load), .hit(hit)
  );

  pnp_card_sel #(.DW(DW), .IDXW(IDXW)) u_sel (
    .clk(clk), .rst_n(rst_n), .hit(hit), .io_wdata(io_wdata),
    .card_handle(card_handle), .idx(cur_idx), .selected(sel),
    .reg_we(reg_we), .rdloc_load(rdloc_load)
  );

  pnp_cfg_regfile #(.DW(DW), .DEPTH(DEPTH)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(cur_idx),
    .wdata(io_wdata), .rdata(reg_rdata)
  );

  assign rd_grant = hit.data_rd && sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_oe   <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_oe   <= rd_grant;
      rd_data <= rd_grant ? reg_rdata : '0;
    end
  end

  assign card_sel = sel;
endmodule

// File: rtl/pnp_cfg_port_chk.sv
module pnp_cfg_port_chk #(
  parameter int AW   = 12,
  parameter int DW   = 8,
  parameter int IDXW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   io_addr,
  input logic [DW-1:0]   io_wdata,
  input logic            io_rd,
  input logic            io_wr,
  input logic [DW-1:0]   card_handle,
  input logic [DW-1:0]   rd_data,
  input logic            rd_oe,
  input logic            card_sel,
  input logic [IDXW-1:0] idx
);
  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == AW'('h279)) |=> (idx == $past(io_wdata[IDXW-1:0])));

  // R3
  sel_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == AW'('hA79) && idx == IDXW'(6))
      |=> (card_sel == ($past(io_wdata) == $past(card_handle))));

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == AW'('hA79)) |=> $stable(card_sel));

  // R6
  oe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> ($past(io_rd) && $past(card_sel)));

  // R6
  oe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> !rd_oe);

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0));

  // R8
  fixed_loc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (io_addr == AW'('h279) || io_addr == AW'('hA79))) |=> !rd_oe);
endmodule

bind pnp_cfg_port pnp_cfg_port_chk #(.AW(AW), .DW(DW), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_rd(io_rd), .io_wr(io_wr), .card_handle(card_handle),
  .rd_data(rd_data), .rd_oe(rd_oe), .card_sel(card_sel), .idx(cur_idx)
);

// File: tb/sim_pnp_cfg_port.sv
`timescale 1ns/1ps
module sim_pnp_cfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  card_handle = 8'h5A;
  logic [7:0]  rd_data;
  logic        rd_oe;
  logic        card_sel;

  always #4 clk = ~clk;  // 125 MHz

  pnp_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .card_handle(card_handle),
    .rd_data(rd_data), .rd_oe(rd_oe), .card_sel(card_sel)
  );

  // Behavioural reference model
  int    m_reg [256];
  int    m_idx, m_rdloc;
  bit    m_sel, m_rden;
  bit    e_oe;
  int    e_data;
  int    checks = 0, errors = 0;
  string cur_req = "R1";
  int    cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_idx = 0; m_sel = 0; m_rden = 0; m_rdloc = 0;
      e_oe = 0; e_data = 0;
    end else begin
      e_oe   = io_rd && m_rden && (int'(io_addr) == m_rdloc) && m_sel;
      e_data = e_oe ? m_reg[m_idx] : 0;
      if (io_wr && io_addr == 12'h279) begin
        m_idx = int'(io_wdata);
      end else if (io_wr && io_addr == 12'hA79) begin
        if (m_idx == 6) begin
          m_sel = (io_wdata == card_handle);
        end else if (m_sel) begin
          m_reg[m_idx] = int'(io_wdata);
          if (m_idx == 0) begin
            m_rdloc = int'(io_wdata) * 4 + 3;
            m_rden  = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 0) begin
      checks++;
      if (rd_oe !== e_oe || int'(rd_data) != e_data || card_sel !== m_sel) begin
        errors++;
        $display("FAIL %s: oe=%0b data=%02h sel=%0b expected oe=%0b data=%02h sel=%0b",
                 cur_req, rd_oe, rd_data, card_sel, e_oe, e_data[7:0], m_sel);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      io_rd = 0; io_wr = 0;
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1; io_rd = 0;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1; io_wr = 0;
    @(negedge clk);
    io_rd = 0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    wr(12'h279, i);
    wr(12'hA79, d);
  endtask

  // Explicit spot check of a read result, in the cycle it is due
  task automatic read_expect(input logic [11:0] a, input bit oe, input int d, input string req);
    @(negedge clk);
    io_addr = a; io_rd = 1; io_wr = 0;
    @(negedge clk);
    io_rd = 0;
    checks++;
    if (rd_oe !== oe || int'(rd_data) != d) begin
      errors++;
      $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h", req, rd_oe, rd_data, oe, d[7:0]);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = 32'h1234_5678;
    cur_req = "R1";
    idle(3);
    rst_n = 1;
    idle(2);
    read_expect(12'h203, 0, 0, "R1");
    read_expect(12'h003, 0, 0, "R1");

    cur_req = "R3";
    reg_wr(8'h06, 8'h33);
    reg_wr(8'h06, 8'h5A);
    idle(1);
    checks++;
    if (card_sel !== 1'b1) begin
      errors++; $display("FAIL R3: card_sel=%0b expected 1", card_sel);
    end

    cur_req = "R5";
    reg_wr(8'h00, 8'h80);
    read_expect(12'h203, 1, 'h80, "R5");

    cur_req = "R2";
    wr(12'h679, 8'h11);
    wr(12'h278, 8'h12);
    read_expect(12'h203, 1, 'h80, "R2");

    cur_req = "R4";
    reg_wr(8'h10, 8'hA1);
    reg_wr(8'h11, 8'hB2);
    reg_wr(8'h12, 8'hC3);
    wr(12'h279, 8'h10);
    read_expect(12'h203, 1, 'hA1, "R4");
    wr(12'h279, 8'h12);
    read_expect(12'h203, 1, 'hC3, "R6");
    wr(12'hA78, 8'hEE);
    wr(12'h279, 8'h12);
    read_expect(12'h203, 1, 'hC3, "R4");

    cur_req = "R7";
    reg_wr(8'h06, 8'h00);
    reg_wr(8'h11, 8'h77);
    read_expect(12'h203, 0, 0, "R7");
    reg_wr(8'h06, 8'h5A);
    wr(12'h279, 8'h11);
    read_expect(12'h203, 1, 'hB2, "R4");
    read_expect(12'h207, 0, 0, "R7");

    cur_req = "R8";
    read_expect(12'h279, 0, 0, "R8");
    read_expect(12'hA79, 0, 0, "R8");
    wr(12'h203, 8'h99);
    read_expect(12'h203, 1, 'hB2, "R8");

    cur_req = "R5";
    reg_wr(8'h00, 8'hFF);
    read_expect(12'h203, 0, 0, "R5");
    read_expect(12'h3FF, 1, 'hFF, "R5");

    cur_req = "R6";
    wr(12'h279, 8'h06);
    read_expect(12'h3FF, 1, 0, "R6");

    // Mixed traffic, compared every cycle against the model
    cur_req = "R6";
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [7:0] d;
      seed = seed * 1103515245 + 12345;
      op = (seed >>> 16) & 7;
      d  = 8'((seed >>> 8) & 255);
      case (op)
        0: wr(12'h279, {5'd0, d[2:0]} | (d[7] ? 8'h10 : 8'h00));
        1: wr(12'hA79, d);
        2: wr(12'hA79, d[0] ? 8'h5A : d);
        3: rd(12'(m_rdloc));
        4: rd(12'h203 + 12'(d[1:0]) * 4);
        5: begin @(negedge clk); io_addr = 12'(m_rdloc); io_rd = 1; io_wr = d[0]; io_wdata = d; end
        default: idle(1);
      endcase
    end
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule